// File: doc/BRIEF.md
# Serial Flash Read Sequencer

This block is the host side of a single-lane serial flash read. A request is taken in one handshake and carries everything the transfer needs: an 8-bit opcode, a start address, a choice of 3-byte or 4-byte address, the number of latency (dummy) clock cycles and the number of bytes to fetch. The sequencer then lowers chip select, generates a mode-0 serial clock from a programmable divider of the system clock and shifts out the opcode and the address. It lets the programmed latency window pass with its data driver switched off and captures the returned bytes, which leave on a valid/ready byte stream. When the last byte has been taken in, it raises chip select and keeps it high for a fixed guard time before it accepts the next request.

The latency count may be zero. In that case the first data bit is launched by the device on the very falling edge that ends the last address bit. A request may also ask for the double-rate training-pattern option. That pattern needs four clock cycles inside the latency window plus one for bus turnaround. Such a request with a latency below five is refused at acceptance. A refused request never touches the serial lines. An abort input ends a read early, but never while the command, address or latency cycles are still running. A downstream consumer that is not ready holds the serial clock still, so no byte is lost.

Top module: `flash_rd_seq`

## Requirements
- R1: The serial clock is low whenever chip select is high. During a transfer each clock half lasts exactly cfg_div+1 system clocks, and only the low half ahead of a byte's last bit can be stretched by a stall.
- R2: The opcode is sent first, then the address, both most significant bit first. The address is 32 bits when req_addr4 is 1 and the low 24 bits when it is 0. `mosi` changes only while `sck` is low, so the device samples it on rising edges.
- R3: Between the slot of the last address bit and the slot of the first data bit lie exactly req_dummy bit slots, each one counted from falling edge to falling edge. With req_dummy = 0 the first data bit is sampled on the rising edge right after the last address bit.
- R4: `mosi_oe` is 1 while opcode and address bits are sent. It goes to 0 on the falling edge that ends the last address bit, which is before the end of the last latency cycle. It stays 0 for the latency and data cycles.
- R5: `miso` is sampled on rising edges. A byte is assembled most significant bit first and appears on `rd_data` with `rd_valid` only after all 8 of its bits are in. Successive bytes belong to successive addresses.
- R6: While `rd_valid` is 1 and `rd_ready` is 0, a held byte stays stable. The serial clock is held low before the last bit of the next byte, so no byte is dropped.
- R7: After req_len bytes, chip select rises at the end of the last bit slot. It then stays high for exactly CS_GAP system clocks with `req_ready` at 0 before a new request is accepted.
- R8: A pulse on `abort_req` during command, address or latency cycles is held pending. Chip select then rises at the end of the first data bit slot and never earlier, and any partial byte is discarded. A pulse while idle has no effect on the next read.
- R9: A request with req_len = 0, or with req_dlp = 1 and req_dummy < 5, is refused. `req_err` is 1 for one cycle, chip select stays high and `req_ready` returns to 1. With req_dlp = 1 and req_dummy of 5 or more the read runs normally, and the pattern cycles are treated as latency.
- R10: After reset, `cs_n` is 1, `sck` is 0, `mosi_oe` is 0, `rd_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_div | input | DIV_W | Serial clock half period minus one, in system clocks; latched per request |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_opcode | input | 8 | Command byte |
| req_addr | input | 32 | Start address |
| req_addr4 | input | 1 | 1 = 4-byte address, 0 = 3-byte address |
| req_dummy | input | DUMMY_W | Latency cycles between address and data |
| req_dlp | input | 1 | Training-pattern option requested |
| req_len | input | LEN_W | Number of bytes to read |
| req_err | output | 1 | One-cycle pulse: request refused |
| abort_req | input | 1 | Request to end the read early |
| sck | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the device |
| mosi_oe | output | 1 | Output enable for `mosi` |
| miso | input | 1 | Serial data from the device |
| rd_data | output | 8 | Returned byte |
| rd_valid | output | 1 | `rd_data` holds a byte |
| rd_ready | input | 1 | Consumer takes the byte |

## Verification
The assertions assume that `miso` changes only after falling serial clock edges, as a mode-0 device does. They also assume that `rd_ready` may drop at any time, and that `abort_req` and request fields count only on the cycles where they are sampled. The bench device model drives `miso` only from falling edges of `sck`, and it holds `cfg_div` and the request fields steady whenever a request is presented. Its abort pulses fall either in the idle state or well inside the address phase, so the expected end of the read is known to the bit slot. Random consumer back-pressure and random latency, length, divider and address width are drawn from a fixed seed, together with directed zero-latency, boundary-latency, refusal and address-wrap cases.

// File: rtl/frs_pkg.sv
// Shared types for the serial flash read sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package frs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2
    } frs_state_e;

    typedef enum logic [1:0] {
        PH_CMD_ADDR = 2'd0,
        PH_LATENCY  = 2'd1,
        PH_DATA     = 2'd2
    } frs_phase_e;

    // Training pattern takes four cycles plus one turnaround cycle.
    localparam int DLP_MIN_DUMMY = 5;

    // Opcode plus the widest address, in bits.
    localparam int TX_BITS = 40;

endpackage

// File: rtl/frs_half_timer.sv
// Half-period timer for the serial clock.
// Counts system clocks while run is high and fires tick on the last clock
// of each half period (div+1 clocks long). hold freezes the count, which
// stretches the current half. Assumes div is stable while run is high.
module frs_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hold,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             at_end;

    assign at_end = (cnt_q == div);
    assign tick   = run && !hold && at_end;

    // Count clocks inside the current half period; restart when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (!hold) begin
            cnt_q <= at_end ? '0 : cnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/frs_rx_byte.sv
// Byte assembler and one-entry output register.
// Shifts in one bit per sample strobe, MSB first. On the strobe flagged as
// last_bit the full byte is loaded into the output register. Assumes the
// caller never strobes a last bit while the register is full and not taken.
module frs_rx_byte (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample,
    input  logic       din,
    input  logic       last_bit,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_valid
);

    logic [6:0] part_q;
    logic       load;

    assign load = sample && last_bit;

    // Collect the leading seven bits of the byte in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_q <= '0;
        end else if (sample) begin
            part_q <= {part_q[5:0], din};
        end
    end

    // Present a finished byte and hold it until the consumer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
        end else if (load) begin
            out_data  <= {part_q, din};
            out_valid <= 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    AST_HELD_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
    AST_LOAD_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n) load |-> !(out_valid && !out_ready)); // R6

endmodule

// File: rtl/flash_rd_seq.sv
// Host-side serial flash read sequencer (single data lane, mode 0).
// Accepts one read request, drives opcode and address MSB first, lets the
// programmed latency cycles pass with the driver released, captures data
// bytes and streams them out, then ends the transfer and guards chip select.
// Assumes miso changes only after falling sck edges.
module flash_rd_seq
    import frs_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int LEN_W   = 16,
    parameter int DUMMY_W = 5,
    parameter int CS_GAP  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [7:0]         req_opcode,
    input  logic [31:0]        req_addr,
    input  logic               req_addr4,
    input  logic [DUMMY_W-1:0] req_dummy,
    input  logic               req_dlp,
    input  logic [LEN_W-1:0]   req_len,
    output logic               req_err,
    input  logic               abort_req,
    output logic               sck,
    output logic               cs_n,
    output logic               mosi,
    output logic               mosi_oe,
    input  logic               miso,
    output logic [7:0]         rd_data,
    output logic               rd_valid,
    input  logic               rd_ready
);

    localparam int CNT_W = (DUMMY_W > 6) ? DUMMY_W : 6;
    localparam int GAP_W = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;

    frs_state_e           state_q;
    frs_phase_e           phase_q;
    logic                 sck_q;
    logic                 cs_n_q;
    logic                 oe_q;
    logic                 err_q;
    logic                 abort_q;
    logic [TX_BITS-1:0]   tx_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [2:0]           bit_q;
    logic [LEN_W-1:0]     left_q;
    logic [DIV_W-1:0]     div_q;
    logic [DUMMY_W-1:0]   dummy_q;
    logic [GAP_W-1:0]     gap_q;

    logic tick, hold, rise, slot_end, in_xfer, in_data, req_bad;

    assign in_xfer  = (state_q == ST_XFER);
    assign in_data  = in_xfer && (phase_q == PH_DATA);
    // Stall before the last bit of a byte while the output is still occupied.
    assign hold     = in_data && !sck_q && (bit_q == 3'd7) && rd_valid && !rd_ready;
    assign rise     = tick && !sck_q;
    assign slot_end = tick && sck_q;
    assign req_bad  = (req_len == '0) || (req_dlp && (int'(req_dummy) < DLP_MIN_DUMMY));

    assign req_ready = (state_q == ST_IDLE);
    assign req_err   = err_q;
    assign sck       = sck_q;
    assign cs_n      = cs_n_q;
    assign mosi_oe   = oe_q;
    assign mosi      = oe_q ? tx_q[TX_BITS-1] : 1'b0;

    frs_half_timer #(.DIV_W(DIV_W)) i_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (in_xfer),
        .hold (hold),
        .div  (div_q),
        .tick (tick)
    );

    frs_rx_byte i_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (rise && in_data),
        .din      (miso),
        .last_bit (bit_q == 3'd7),
        .out_ready(rd_ready),
        .out_data (rd_data),
        .out_valid(rd_valid)
    );

    // Sequence one read: accept, shift out, latency, capture, end and guard.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= PH_CMD_ADDR;
            sck_q   <= 1'b0;
            cs_n_q  <= 1'b1;
            oe_q    <= 1'b0;
            err_q   <= 1'b0;
            abort_q <= 1'b0;
            tx_q    <= '0;
            cnt_q   <= '0;
            bit_q   <= '0;
            left_q  <= '0;
            div_q   <= '0;
            dummy_q <= '0;
            gap_q   <= '0;
        end else begin
            err_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid && req_bad) begin
                        err_q <= 1'b1;
                    end else if (req_valid) begin
                        state_q <= ST_XFER;
                        phase_q <= PH_CMD_ADDR;
                        cs_n_q  <= 1'b0;
                        oe_q    <= 1'b1;
                        sck_q   <= 1'b0;
                        abort_q <= 1'b0;
                        tx_q    <= req_addr4 ? {req_opcode, req_addr}
                                             : {req_opcode, req_addr[23:0], 8'h00};
                        cnt_q   <= req_addr4 ? CNT_W'(39) : CNT_W'(31);
                        bit_q   <= '0;
                        left_q  <= req_len;
                        div_q   <= cfg_div;
                        dummy_q <= req_dummy;
                    end
                end
                ST_XFER: begin
                    if (abort_req) begin
                        abort_q <= 1'b1;
                    end
                    if (rise) begin
                        sck_q <= 1'b1;
                    end else if (slot_end) begin
                        sck_q <= 1'b0;
                        case (phase_q)
                            PH_CMD_ADDR: begin
                                if (cnt_q == '0) begin
                                    oe_q <= 1'b0;
                                    if (dummy_q != '0) begin
                                        phase_q <= PH_LATENCY;
                                        cnt_q   <= CNT_W'(dummy_q) - CNT_W'(1);
                                    end else begin
                                        phase_q <= PH_DATA;
                                    end
                                end else begin
                                    cnt_q <= cnt_q - CNT_W'(1);
                                    tx_q  <= {tx_q[TX_BITS-2:0], 1'b0};
                                end
                            end
                            PH_LATENCY: begin
                                if (cnt_q == '0) begin
                                    phase_q <= PH_DATA;
                                end else begin
                                    cnt_q <= cnt_q - CNT_W'(1);
                                end
                            end
                            default: begin
                                if (abort_q || ((bit_q == 3'd7) && (left_q == LEN_W'(1)))) begin
                                    cs_n_q  <= 1'b1;
                                    state_q <= ST_GAP;
                                    gap_q   <= '0;
                                end else begin
                                    bit_q <= bit_q + 3'd1;
                                    if (bit_q == 3'd7) begin
                                        left_q <= left_q - LEN_W'(1);
                                    end
                                end
                            end
                        endcase
                    end
                end
                default: begin
                    if (gap_q == GAP_W'(CS_GAP - 1)) begin
                        state_q <= ST_IDLE;
                    end else begin
                        gap_q <= gap_q + GAP_W'(1);
                    end
                end
            endcase
        end
    end

    AST_SCK_LOW_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck); // R1
    AST_MOSI_STILL_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (sck && $past(sck)) |-> $stable(mosi)); // R2
    AST_DRIVER_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) (in_xfer && (phase_q != PH_CMD_ADDR)) |-> !mosi_oe); // R4
    AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |=> (cs_n && !req_ready)); // R7
    AST_CS_RISES_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |-> ($past(phase_q) == PH_DATA)); // R8
    AST_REFUSE_SHORT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready && req_dlp && (int'(req_dummy) < DLP_MIN_DUMMY)) |=> (req_err && cs_n)); // R9

endmodule

// File: tb/test_flash_rd_seq.sv
// Bench for flash_rd_seq: a behavioural mode-0 device model, a random
// consumer, directed corner cases and seeded random reads.
module test_flash_rd_seq;

    localparam int DIV_W   = 8;
    localparam int LEN_W   = 16;
    localparam int DUMMY_W = 5;
    localparam int CS_GAP  = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [DIV_W-1:0]   cfg_div = '0;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [7:0]         req_opcode = '0;
    logic [31:0]        req_addr = '0;
    logic               req_addr4 = 1'b0;
    logic [DUMMY_W-1:0] req_dummy = '0;
    logic               req_dlp = 1'b0;
    logic [LEN_W-1:0]   req_len = '0;
    logic               req_err;
    logic               abort_req = 1'b0;
    logic               sck, cs_n, mosi, mosi_oe;
    logic               miso = 1'b0;
    logic [7:0]         rd_data;
    logic               rd_valid;
    logic               rd_ready = 1'b0;

    always #10 clk = ~clk;

    flash_rd_seq #(.DIV_W(DIV_W), .LEN_W(LEN_W), .DUMMY_W(DUMMY_W), .CS_GAP(CS_GAP)) i_flash_rd_seq (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div),
        .req_valid(req_valid), .req_ready(req_ready), .req_opcode(req_opcode),
        .req_addr(req_addr), .req_addr4(req_addr4), .req_dummy(req_dummy),
        .req_dlp(req_dlp), .req_len(req_len), .req_err(req_err),
        .abort_req(abort_req), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .mosi_oe(mosi_oe), .miso(miso), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Expected transfer shape, set before each request.
    logic [7:0]  e_op;
    logic [31:0] e_base;
    int          e_alen = 24;
    int          e_d = 0;
    int          e_div = 0;
    bit          stall_mode = 1'b0;

    // Device model state.
    int          rcnt = 0, fcnt = 0, idx = 0, oe_bad = 0;
    logic [7:0]  got_op = '0;
    logic [31:0] got_addr = '0;

    // Monitor and consumer state.
    int          per_bad = 0, idle_bad = 0, hi_run = 0;
    int          rx_n = 0;
    logic [7:0]  rx_q [64];

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ a[31:24] ^ 8'h3C;
    endfunction

    function automatic logic [31:0] byte_addr(input int i);
        logic [31:0] s;
        s = e_base + 32'(i);
        return (e_alen == 32) ? s : (s & 32'h00FF_FFFF);
    endfunction

    // Device: restart its counters at every selection.
    always @(negedge cs_n) begin
        rcnt = 0; fcnt = 0; oe_bad = 0; got_op = '0; got_addr = '0;
    end

    // Device: take opcode and address on rising edges, watch the host driver.
    always @(posedge sck) begin
        if (!cs_n) begin
            rcnt++;
            if (rcnt <= 8) got_op = {got_op[6:0], mosi};
            else if (rcnt <= 8 + e_alen) got_addr = {got_addr[30:0], mosi};
            if ((rcnt <= 8 + e_alen) != mosi_oe) oe_bad++;
        end
    end

    // Device: launch data bits on falling edges after the latency cycles.
    always @(negedge sck) begin
        if (!cs_n) begin
            fcnt++;
            if (fcnt >= 8 + e_alen + e_d) begin
                idx = fcnt - (8 + e_alen + e_d);
                miso = mem_byte(byte_addr(idx / 8))[7 - (idx % 8)];
            end
        end
    end

    // Monitor: serial clock high-half length and idle level.
    initial forever begin
        @(negedge clk);
        if (!cs_n) begin
            if (sck) hi_run++;
            else begin
                if (hi_run != 0 && hi_run != e_div + 1) per_bad++;
                hi_run = 0;
            end
        end else begin
            hi_run = 0;
            if (sck) idle_bad++;
        end
    end

    // Consumer: random back-pressure, records every byte handed over.
    initial forever begin
        bit rdy;
        @(negedge clk);
        rdy = stall_mode ? (($urandom % 3) != 0) : 1'b1;
        rd_ready = rdy;
        if (rd_valid === 1'b1 && rdy) begin
            if (rx_n < 64) rx_q[rx_n] = rd_data;
            rx_n++;
        end
    end

    task automatic run_read(input logic [7:0] op, input logic [31:0] addr, input bit a4,
                            input int d, input bit dlp, input int len, input int div,
                            input int abort_at, input bit stall);
        int g, rend, bad_i;
        bit ok;
        while (!req_ready) @(negedge clk);
        e_op = op; e_alen = a4 ? 32 : 24; e_base = a4 ? addr : (addr & 32'h00FF_FFFF);
        e_d = d; e_div = div; stall_mode = stall; rx_n = 0; per_bad = 0; idle_bad = 0;
        cfg_div = DIV_W'(div); req_opcode = op; req_addr = addr; req_addr4 = a4;
        req_dummy = DUMMY_W'(d); req_dlp = dlp; req_len = LEN_W'(len); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (abort_at >= 0) begin
            repeat (abort_at) @(negedge clk);
            abort_req = 1'b1;
            @(negedge clk);
            abort_req = 1'b0;
        end
        while (!cs_n) @(negedge clk);
        rend = rcnt;
        g = 0;
        while (!req_ready) begin g++; @(negedge clk); end
        while (rd_valid) @(negedge clk);
        check(got_op == op, "R2", "opcode", got_op, op);
        check(got_addr == e_base, "R2", "address", got_addr, e_base);
        check(oe_bad == 0, "R4", "driver enable slots wrong", oe_bad, 0);
        check(per_bad == 0 && idle_bad == 0, "R1", "clock half length or idle level", per_bad + idle_bad, 0);
        check(g == CS_GAP, "R7", "chip select guard clocks", g, CS_GAP);
        if (abort_at >= 0) begin
            check(rend == 8 + e_alen + d + 1, "R8", "rising edges at abort end", rend, 8 + e_alen + d + 1);
            check(rx_n == 0, "R8", "bytes after abort", rx_n, 0);
        end else begin
            check(rx_n == len, stall ? "R6" : "R7", "byte count", rx_n, len);
            ok = 1'b1; bad_i = -1;
            for (int i = 0; i < len && i < 64; i++) begin
                if (ok && rx_q[i] != mem_byte(byte_addr(i))) begin ok = 1'b0; bad_i = i; end
            end
            if (bad_i >= 0)
                check(1'b0, (d == 0) ? "R3" : "R5", "data byte", rx_q[bad_i], mem_byte(byte_addr(bad_i)));
            else
                check(1'b1, (d == 0) ? "R3" : "R5", "data bytes", 0, 0);
        end
    endtask

    task automatic bad_req(input bit dlp, input int d, input int len);
        while (!req_ready) @(negedge clk);
        req_dlp = dlp; req_dummy = DUMMY_W'(d); req_len = LEN_W'(len); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_err == 1'b1 && cs_n == 1'b1, "R9", "refusal pulse with chip select high", {req_err, cs_n}, 3);
        @(negedge clk);
        check(req_err == 1'b0 && req_ready == 1'b1 && cs_n == 1'b1, "R9", "back to idle", {req_err, req_ready, cs_n}, 3);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n == 1'b1, "R10", "cs_n after reset", cs_n, 1);
        check(sck == 1'b0, "R10", "sck after reset", sck, 0);
        check(mosi_oe == 1'b0, "R10", "mosi_oe after reset", mosi_oe, 0);
        check(rd_valid == 1'b0, "R10", "rd_valid after reset", rd_valid, 0);
        check(req_ready == 1'b1, "R10", "req_ready after reset", req_ready, 1);

        run_read(8'h03, 32'h0012_3456, 1'b0, 0, 1'b0, 3, 0, -1, 1'b0);
        run_read(8'h13, 32'hA0B1_C2D3, 1'b1, 0, 1'b0, 2, 1, -1, 1'b0);
        run_read(8'h0B, 32'h0000_1000, 1'b0, 5, 1'b1, 4, 1, -1, 1'b0);
        run_read(8'hEE, 32'h7654_3210, 1'b1, 8, 1'b1, 4, 2, -1, 1'b0);
        bad_req(1'b1, 4, 3);
        bad_req(1'b1, 0, 3);
        bad_req(1'b0, 2, 0);
        // Abort while idle must not shorten the next read (R8).
        @(negedge clk); abort_req = 1'b1; @(negedge clk); abort_req = 1'b0;
        run_read(8'h03, 32'h00FF_FFFE, 1'b0, 1, 1'b0, 4, 0, -1, 1'b0);
        run_read(8'h0B, 32'h0000_0040, 1'b0, 3, 1'b0, 6, 1, 5, 1'b0);
        run_read(8'h0C, 32'h1234_0000, 1'b1, 0, 1'b0, 5, 0, 20, 1'b1);
        run_read(8'h0B, 32'h0000_2222, 1'b0, 2, 1'b0, 12, 0, -1, 1'b1);

        for (int n = 0; n < 24; n++) begin
            bit a4, dlp, stall;
            int d, len, div, ab;
            a4 = 1'($urandom % 2);
            d = int'($urandom % 9);
            dlp = (d >= 5) ? 1'($urandom % 2) : 1'b0;
            len = 1 + int'($urandom % 12);
            div = int'($urandom % 4);
            stall = 1'($urandom % 2);
            ab = (($urandom % 6) == 0) ? int'($urandom % 40) : -1;
            run_read(8'($urandom), $urandom, a4, d, dlp, len, div, ab, stall);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule